// File: doc/BRIEF.md
# Loudness-Triggered Start Pulse Generator

This block watches a stream of parallel 16-bit audio samples, each flagged by a one-cycle valid strobe. It takes a 5-bit coarse loudness code from every valid sample and compares it with a threshold input. A sample at or above the threshold fires a start pulse. The pulse is a fixed number of clock cycles long, two by default. A lockout window of about one second follows the pulse, and during it every sample is ignored. A single shout therefore produces one start event, not a burst of them.

The control is a three-state machine:
- `ST_IDLE` is the only state that looks at samples. It moves to `ST_PULSE` on a qualifying sample.
- `ST_PULSE` drives the output high. It moves to `ST_LOCK` when the shared down-counter reaches zero.
- `ST_LOCK` holds the output low. It returns to `ST_IDLE` when the counter reaches zero again.

The counter is loaded with the pulse length on entry to `ST_PULSE` and with the lockout length on entry to `ST_LOCK`. Both lengths are parameters given in clock cycles. The default lockout is 50,000,000 cycles, which is one second at 50 MHz.

Top module: `loud_start_trigger`

## Requirements
- R1: The loudness code is the unsigned value of sample bits [14:10], where 31 means the loudest level (+12 dB) and 0 the quietest (-34.5 dB). Sample bits 15 and 9:0 have no effect on triggering.
- R2: In `ST_IDLE`, a sample with `smp_valid` high and a code greater than or equal to `thresh` triggers. Equality triggers, and a code of `thresh`-1 does not.
- R3: A sample presented while `smp_valid` is low never triggers, whatever its code.
- R4: `start_pulse` rises in the cycle after the clock edge that samples the triggering input. It stays high for exactly PULSE_CYC cycles (default 2), then falls.
- R5: After the pulse, `start_pulse` stays low for LOCK_CYC cycles in `ST_LOCK`, and every sample in that window is ignored. With a qualifying sample held continuously, consecutive pulses are separated by exactly LOCK_CYC+1 low cycles.
- R6: After the lockout, the block is armed again: the next qualifying sample triggers a new pulse with the R4 timing.
- R7: Asserting `rst_n` low, even in the middle of a pulse, forces `start_pulse` low and returns the machine to `ST_IDLE`. After release, the next qualifying sample triggers without any lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Strobe marking `smp_data` as a new sample |
| smp_data | input | 16 | Parallel audio sample |
| thresh | input | 5 | Loudness code at or above which a trigger occurs |
| start_pulse | output | 1 | Start event, high for PULSE_CYC cycles per trigger |

## Verification
A qualifying sample that is driven before a clock edge shows up on `start_pulse` one cycle later, in the cycle that follows that edge. The output falls after PULSE_CYC further edges. The block arms again LOCK_CYC+1 edges after the fall. The bench changes inputs on the falling edge and reads `start_pulse` on the next falling edge after each rising edge. Every check therefore lands on the exact cycle these counts predict, and a result that arrives one cycle early or late is caught. The lockout is shortened through its parameter, so the whole low window between pulses is checked cycle by cycle.

// File: rtl/loud_start_pkg.sv
package loud_start_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_LOCK  = 2'd2
    } trig_state_e;

endpackage

// File: rtl/loud_level_cmp.sv
module loud_level_cmp #(
    parameter int SAMPLE_W = 16,
    parameter int LVL_LSB  = 10,
    parameter int LVL_W    = 5
) (
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [LVL_W-1:0]    thresh,
    output logic                hit
);

    logic [SAMPLE_W-1:0] shifted;
    logic [LVL_W-1:0]    level;

    always_comb begin
        shifted = smp_data >> LVL_LSB;
        level   = shifted[LVL_W-1:0];
        hit     = smp_valid && (level >= thresh);
    end

endmodule

// File: rtl/loud_down_counter.sv
module loud_down_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/loud_start_fsm.sv
module loud_start_fsm
    import loud_start_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int PULSE_CYC = 2,
    parameter int LOCK_CYC  = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             cnt_zero,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             pulse
);

    localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LOCK_LOAD  = CNT_W'(LOCK_CYC - 1);

    trig_state_e state_q;
    trig_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (hit)      state_d = ST_PULSE;
            ST_PULSE: if (cnt_zero) state_d = ST_LOCK;
            ST_LOCK:  if (cnt_zero) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // outputs and counter control
    always_comb begin
        pulse    = 1'b0;
        cnt_load = 1'b0;
        cnt_val  = PULSE_LOAD;
        unique case (state_q)
            ST_IDLE: begin
                cnt_load = hit;
                cnt_val  = PULSE_LOAD;
            end
            ST_PULSE: begin
                pulse    = 1'b1;
                cnt_load = cnt_zero;
                cnt_val  = LOCK_LOAD;
            end
            ST_LOCK: begin
                pulse = 1'b0;
            end
            default: begin
                pulse = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/loud_start_trigger.sv
module loud_start_trigger #(
    parameter int SAMPLE_W  = 16,
    parameter int LVL_LSB   = 10,
    parameter int LVL_W     = 5,
    parameter int PULSE_CYC = 2,
    parameter int LOCK_CYC  = 50_000_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [LVL_W-1:0]    thresh,
    output logic                start_pulse
);

    localparam int MAX_CYC = (LOCK_CYC > PULSE_CYC) ? LOCK_CYC : PULSE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             hit;
    logic             cnt_zero;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;

    loud_level_cmp #(
        .SAMPLE_W (SAMPLE_W),
        .LVL_LSB  (LVL_LSB),
        .LVL_W    (LVL_W)
    ) u_cmp (
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .thresh    (thresh),
        .hit       (hit)
    );

    loud_down_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    loud_start_fsm #(
        .CNT_W     (CNT_W),
        .PULSE_CYC (PULSE_CYC),
        .LOCK_CYC  (LOCK_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .cnt_zero (cnt_zero),
        .cnt_load (cnt_load),
        .cnt_val  (cnt_val),
        .pulse    (start_pulse)
    );

endmodule

// File: rtl/loud_start_chk.sv
module loud_start_chk #(
    parameter int SAMPLE_W  = 16,
    parameter int LVL_LSB   = 10,
    parameter int LVL_W     = 5,
    parameter int PULSE_CYC = 2,
    parameter int LOCK_CYC  = 50_000_000
) (
    input logic                clk,
    input logic                rst_n,
    input logic                smp_valid,
    input logic [SAMPLE_W-1:0] smp_data,
    input logic [LVL_W-1:0]    thresh,
    input logic                start_pulse
);

    localparam int LOW_W = $clog2(LOCK_CYC + 2);
    localparam int HI_W  = $clog2(PULSE_CYC + 1);
    localparam logic [LOW_W-1:0] LOW_SAT = LOW_W'(LOCK_CYC + 1);
    localparam logic [HI_W-1:0]  HI_SAT  = HI_W'(PULSE_CYC);

    logic [SAMPLE_W-1:0] shifted;
    logic [LVL_W-1:0]    lvl;
    logic [LOW_W-1:0]    low_run;
    logic [HI_W-1:0]     hi_run;
    logic                had_pulse;

    always_comb begin
        shifted = smp_data >> LVL_LSB;
        lvl     = shifted[LVL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run   <= '0;
            hi_run    <= '0;
            had_pulse <= 1'b0;
        end else begin
            if (start_pulse) begin
                low_run   <= '0;
                had_pulse <= 1'b1;
                if (hi_run != HI_SAT) hi_run <= hi_run + 1'b1;
            end else begin
                hi_run <= '0;
                if (low_run != LOW_SAT) low_run <= low_run + 1'b1;
            end
        end
    end

    // R4
    pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_run != '0 && hi_run < HI_SAT) |-> start_pulse);

    // R4
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_run == HI_SAT) |-> !start_pulse);

    // R2
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_pulse) |-> $past(smp_valid && (lvl >= thresh)));

    // R5
    lockout_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (had_pulse && $rose(start_pulse)) |-> (low_run >= LOW_SAT));

    // R7
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |-> !start_pulse);

endmodule

bind loud_start_trigger loud_start_chk #(
    .SAMPLE_W  (SAMPLE_W),
    .LVL_LSB   (LVL_LSB),
    .LVL_W     (LVL_W),
    .PULSE_CYC (PULSE_CYC),
    .LOCK_CYC  (LOCK_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_valid   (smp_valid),
    .smp_data    (smp_data),
    .thresh      (thresh),
    .start_pulse (start_pulse)
);

// File: tb/test_loud_start_trigger.sv
module test_loud_start_trigger;

    localparam int CLK_PERIOD = 10;
    localparam int LOCK_TB    = 12;
    localparam int PULSE_TB   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic [4:0]  thresh = 5'd20;
    logic        start_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    loud_start_trigger #(
        .PULSE_CYC (PULSE_TB),
        .LOCK_CYC  (LOCK_TB)
    ) i_loud_start_trigger (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid   (smp_valid),
        .smp_data    (smp_data),
        .thresh      (thresh),
        .start_pulse (start_pulse)
    );

    function automatic logic [15:0] mk(input logic [4:0] lvl, input logic other);
        return {other, lvl, {10{other}}};
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: start_pulse=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        smp_valid = 1'b0;
        repeat (LOCK_TB + PULSE_TB + 3) step();
    endtask

    task automatic t_reset();
        step();
        check(start_pulse, 1'b0, "R7 reset state");
        rst_n = 1'b1;
        repeat (3) begin
            step();
            check(start_pulse, 1'b0, "R7 idle after reset");
        end
    endtask

    task automatic t_below();
        thresh    = 5'd20;
        smp_valid = 1'b1;
        smp_data  = mk(5'd19, 1'b1);
        repeat (5) begin
            step();
            check(start_pulse, 1'b0, "R1 R2 code below threshold");
        end
        smp_valid = 1'b0;
        smp_data  = mk(5'd31, 1'b1);
        repeat (5) begin
            step();
            check(start_pulse, 1'b0, "R3 valid low ignored");
        end
    endtask

    task automatic t_held();
        thresh    = 5'd20;
        smp_valid = 1'b1;
        smp_data  = mk(5'd20, 1'b0);
        for (int i = 0; i < PULSE_TB; i++) begin
            step();
            check(start_pulse, 1'b1, "R2 R4 pulse high");
        end
        for (int i = 0; i < LOCK_TB + 1; i++) begin
            step();
            check(start_pulse, 1'b0, "R5 lockout ignores loud");
        end
        step();
        check(start_pulse, 1'b1, "R6 rearm after lockout");
        step();
        check(start_pulse, 1'b1, "R6 R4 second pulse cycle");
        smp_valid = 1'b0;
        step();
        check(start_pulse, 1'b0, "R4 second pulse ends");
        settle();
    endtask

    task automatic t_edges();
        thresh    = 5'd0;
        smp_valid = 1'b1;
        smp_data  = mk(5'd0, 1'b0);
        step();
        smp_valid = 1'b0;
        check(start_pulse, 1'b1, "R2 zero threshold triggers");
        settle();
        thresh    = 5'd31;
        smp_valid = 1'b1;
        smp_data  = mk(5'd30, 1'b1);
        step();
        check(start_pulse, 1'b0, "R1 other bits ignored");
        smp_data  = mk(5'd31, 1'b0);
        step();
        smp_valid = 1'b0;
        check(start_pulse, 1'b1, "R1 max code triggers");
        step();
        check(start_pulse, 1'b1, "R4 pulse second cycle");
        step();
        check(start_pulse, 1'b0, "R4 pulse falls");
        settle();
    endtask

    task automatic t_reset_mid();
        thresh    = 5'd10;
        smp_valid = 1'b1;
        smp_data  = mk(5'd15, 1'b0);
        step();
        smp_valid = 1'b0;
        check(start_pulse, 1'b1, "R4 pulse before reset");
        rst_n = 1'b0;
        step();
        check(start_pulse, 1'b0, "R7 reset mid pulse");
        rst_n = 1'b1;
        step();
        check(start_pulse, 1'b0, "R7 low after release");
        smp_valid = 1'b1;
        step();
        smp_valid = 1'b0;
        check(start_pulse, 1'b1, "R7 no lockout after reset");
        settle();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_below();
        t_held();
        t_edges();
        t_reset_mid();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule